// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block keeps the eight status bits of an asynchronous serial port in one byte-wide register. Six of them are event flags: transmit buffer empty, receive buffer full, overrun, framing error, parity error and transmit complete. The other two carry the multiprocessor bit. One holds the value taken from the last received frame. The other holds the value that software wants sent with the next frame.

The transmitter and receiver datapaths raise the event flags through single-cycle strobes. Software clears a flag by a two-step handshake: it reads the register while the flag is 1, then writes 0 to that bit. A transfer controller that moves data in and out of the data registers clears the buffer flags directly. When the transmitter is disabled, both the transmit-empty flag and the transmit-complete flag are forced high.

Top module: `serial_status_reg`

## Requirements
- R1: Synchronous active-high reset sets the register to 0x84: transmit-empty and transmit-complete are 1, and every other bit is 0.
- R2: The register bit positions are 7 transmit-empty, 6 receive-full, 5 overrun, 4 framing error, 3 parity error, 2 transmit-complete, 1 received multiprocessor bit and 0 transmit multiprocessor bit.
- R3: Writing 1 to any of the bits 7..2 has no effect. Writes to bit 1 are always ignored.
- R4: A write of 0 clears a flag among bits 7..3 only if a read since the last write returned that flag as 1. Without such a read the flag keeps its value.
- R5: Every write, whatever its data, cancels all pending read-as-1 permissions.
- R6: Transmit-empty sets on a buffer-to-shift transfer strobe, and in every cycle in which transmit-enable is 0. A transfer-controller write to the transmit buffer clears it.
- R7: Transmit-complete sets when the last-bit strobe arrives while transmit-empty is 1, or when transmit-enable is 0. It clears exactly when a transmit-empty clear is requested, whether by software or by the transfer controller. Its own bit is not writable.
- R8: Receive-full sets on a reception-complete strobe if the stop bit is 1 and there is no parity error. A transfer-controller read of the receive buffer clears it.
- R9: Overrun sets on a reception-complete strobe while receive-full is 1.
- R10: Framing error sets on a reception-complete strobe whose sampled stop bit is 0.
- R11: When parity checking is enabled, parity error sets on reception complete if the count of ones in the data plus the parity bit is odd with the odd input 0 (even mode), or even with the odd input 1 (odd mode).
- R12: The received multiprocessor bit takes the frame's multiprocessor bit on every reception-complete strobe. The transmit multiprocessor bit takes write-data bit 0 on every write and drives `mpb_tx`.
- R13: When a hardware set and a clear request hit a flag in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmitter enabled |
| parity_en | input | 1 | Parity checking enabled |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| bus_rd | input | 1 | CPU read strobe of the register |
| bus_wr | input | 1 | CPU write strobe of the register |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Register contents |
| tx_load | input | 1 | Transmit buffer moved into the shift register |
| tx_last_bit | input | 1 | Last bit of a character being sent |
| rx_done | input | 1 | Reception of a frame complete |
| rx_data | input | DW | Received data bits |
| rx_parity | input | 1 | Received parity bit |
| rx_stop | input | 1 | Sampled stop bit |
| rx_mpb | input | 1 | Received multiprocessor bit |
| xc_tdr_write | input | 1 | Transfer controller wrote the transmit buffer |
| xc_rdr_read | input | 1 | Transfer controller read the receive buffer |
| mpb_tx | output | 1 | Multiprocessor bit for the next transmitted frame |

## Verification
The assertions assume that every strobe is a one-cycle pulse sampled on the rising edge, and that rx_data, rx_parity, rx_stop and rx_mpb are valid in the cycle where rx_done is high. The stimulus keeps to these rules. It changes every input at the falling edge, raises each strobe for exactly one cycle, and holds the frame fields steady across the rx_done cycle. A full sweep over all data bytes, both parity bits and both parity modes drives the receive path. A sweep of every write value, with no earlier read, drives the write path.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  // event-flag index; register bit = 7 - index
  localparam int NFLAG    = 5;
  localparam int F_TXE    = 0;
  localparam int F_RXF    = 1;
  localparam int F_OVR    = 2;
  localparam int F_FRM    = 3;
  localparam int F_PAR    = 4;
  localparam int B_TEND   = 2;
  localparam int B_MPBRX  = 1;
  localparam int B_MPBTX  = 0;
  localparam logic [NFLAG-1:0] FLAG_RST  = 5'b00001;
  // flags whose clear request also clears transmit-complete
  localparam logic [NFLAG-1:0] TEND_LINK = 5'b00001;
  localparam logic [7:0] REG_RST = 8'h84;
endpackage

// File: rtl/ssr_parity_chk.sv
module ssr_parity_chk #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic          pbit,
  input  logic          odd,
  input  logic          en,
  output logic          err
);
  logic ones_odd;
  assign ones_odd = ^{data, pbit};
  assign err      = en && (ones_odd != odd);
endmodule

// File: rtl/ssr_flag_cell.sv
module ssr_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic bus_rd,
  input  logic bus_wr,
  input  logic wr_bit,
  output logic q,
  output logic clr_req
);
  logic armed;
  logic sw_clr;

  assign sw_clr  = bus_wr && !wr_bit && armed;
  assign clr_req = hw_clr || sw_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= RST_VAL;
      armed <= 1'b0;
    end else begin
      if (hw_set)       q <= 1'b1;
      else if (clr_req) q <= 1'b0;
      if (bus_wr)           armed <= 1'b0;
      else if (bus_rd && q) armed <= 1'b1;
    end
  end

  // R13: a set event always leaves the flag high
  p_set_wins_r13: assert property (@(posedge clk) disable iff (rst)
    hw_set |=> q);
  // R4: without a hardware clear or an armed zero write the flag holds
  p_hold_unarmed_r4: assert property (@(posedge clk) disable iff (rst)
    (q && !hw_clr && !(bus_wr && !wr_bit && armed)) |=> q);
  // R5: a write leaves no permission behind
  p_write_disarms_r5: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> !armed);
endmodule

// File: rtl/serial_status_reg.sv
module serial_status_reg
  import ssr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_enable,
  input  logic          parity_en,
  input  logic          parity_odd,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          tx_load,
  input  logic          tx_last_bit,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_parity,
  input  logic          rx_stop,
  input  logic          rx_mpb,
  input  logic          xc_tdr_write,
  input  logic          xc_rdr_read,
  output logic          mpb_tx
);
  logic [NFLAG-1:0] flg;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic [NFLAG-1:0] clr_req;
  logic             perr;
  logic             tend_q;
  logic             tend_set;
  logic             tend_clr;
  logic             mpb_rx_q;
  logic             mpb_tx_q;

  ssr_parity_chk #(.DW(DW)) u_par (
    .data (rx_data),
    .pbit (rx_parity),
    .odd  (parity_odd),
    .en   (parity_en),
    .err  (perr)
  );

  always_comb begin
    set_v         = '0;
    clr_v         = '0;
    set_v[F_TXE]  = tx_load || !tx_enable;
    clr_v[F_TXE]  = xc_tdr_write;
    set_v[F_RXF]  = rx_done && rx_stop && !perr;
    clr_v[F_RXF]  = xc_rdr_read;
    set_v[F_OVR]  = rx_done && flg[F_RXF];
    set_v[F_FRM]  = rx_done && !rx_stop;
    set_v[F_PAR]  = rx_done && perr;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    ssr_flag_cell #(.RST_VAL(FLAG_RST[i])) u_cell (
      .clk     (clk),
      .rst     (rst),
      .hw_set  (set_v[i]),
      .hw_clr  (clr_v[i]),
      .bus_rd  (bus_rd),
      .bus_wr  (bus_wr),
      .wr_bit  (bus_wdata[7-i]),
      .q       (flg[i]),
      .clr_req (clr_req[i])
    );
  end

  assign tend_set = (tx_last_bit && flg[F_TXE]) || !tx_enable;
  assign tend_clr = |(clr_req & TEND_LINK);

  always_ff @(posedge clk) begin
    if (rst) begin
      tend_q   <= REG_RST[B_TEND];
      mpb_rx_q <= 1'b0;
      mpb_tx_q <= 1'b0;
    end else begin
      if (tend_set)      tend_q <= 1'b1;
      else if (tend_clr) tend_q <= 1'b0;
      if (rx_done) mpb_rx_q <= rx_mpb;
      if (bus_wr)  mpb_tx_q <= bus_wdata[B_MPBTX];
    end
  end

  always_comb begin
    for (int i = 0; i < NFLAG; i++) bus_rdata[7-i] = flg[i];
    bus_rdata[B_TEND]  = tend_q;
    bus_rdata[B_MPBRX] = mpb_rx_q;
    bus_rdata[B_MPBTX] = mpb_tx_q;
  end
  assign mpb_tx = mpb_tx_q;

  p_reset_val_r1: assert property (@(posedge clk)
    rst |=> bus_rdata == REG_RST);
  p_tx_off_r6: assert property (@(posedge clk) disable iff (rst)
    !tx_enable |=> (bus_rdata[7] && bus_rdata[B_TEND]));
  p_overrun_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_done && bus_rdata[6]) |=> bus_rdata[5]);
  p_framing_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rx_stop) |=> (bus_rdata[4] && !$past(bus_rdata[6]) == !bus_rdata[6]));
  p_mpb_follow_r12: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> bus_rdata[B_MPBRX] == $past(rx_mpb));
endmodule

// File: tb/test_serial_status_reg.sv
module test_serial_status_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_enable = 1'b0, parity_en = 1'b0, parity_odd = 1'b0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tx_load = 1'b0, tx_last_bit = 1'b0, rx_done = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_parity = 1'b0, rx_stop = 1'b1, rx_mpb = 1'b0;
  logic       xc_tdr_write = 1'b0, xc_rdr_read = 1'b0;
  logic       mpb_tx;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  serial_status_reg i_serial_status_reg (
    .clk(clk), .rst(rst), .tx_enable(tx_enable), .parity_en(parity_en),
    .parity_odd(parity_odd), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_load(tx_load),
    .tx_last_bit(tx_last_bit), .rx_done(rx_done), .rx_data(rx_data),
    .rx_parity(rx_parity), .rx_stop(rx_stop), .rx_mpb(rx_mpb),
    .xc_tdr_write(xc_tdr_write), .xc_rdr_read(xc_rdr_read), .mpb_tx(mpb_tx)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, bus_rdata, exp);
    end
  endtask

  task automatic rd();
    bus_rd = 1'b1; cyc(); bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    bus_wr = 1'b1; bus_wdata = d; cyc(); bus_wr = 1'b0;
  endtask

  task automatic rx(input logic [7:0] d, input logic p, input logic stop, input logic mpb);
    rx_data = d; rx_parity = p; rx_stop = stop; rx_mpb = mpb;
    rx_done = 1'b1; cyc(); rx_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk); cyc(); cyc();
    rst = 1'b0; tx_enable = 1'b1;
    chk("R1 reset value", 8'h84);
    cyc();
    chk("R1 after release", 8'h84);
    // R3 R4 R2 R12: writes without a prior read touch only bit 0
    for (int w = 0; w < 256; w++) begin
      wr(w[7:0]);
      checks++;
      if (bus_rdata !== (8'h84 | {7'd0, w[0]}) || mpb_tx !== w[0]) begin
        errors++;
        $display("FAIL R4 unarmed write %02h actual=%02h expected=%02h",
                 w[7:0], bus_rdata, 8'h84 | {7'd0, w[0]});
      end
    end
    // R7 R4: read then zero write clears transmit-empty and transmit-complete
    rd(); wr(8'h00);
    chk("R7 sw clear links tend", 8'h00);
    // R6 R5
    tx_load = 1'b1; cyc(); tx_load = 1'b0;
    chk("R6 load sets txe", 8'h80);
    rd(); wr(8'hFF);
    chk("R3 ones write", 8'h81);
    wr(8'h01);
    chk("R5 write disarms", 8'h81);
    xc_tdr_write = 1'b1; cyc(); xc_tdr_write = 1'b0;
    chk("R6 controller clears txe", 8'h01);
    tx_last_bit = 1'b1; cyc(); tx_last_bit = 1'b0;
    chk("R7 last bit without txe", 8'h01);
    tx_load = 1'b1; cyc(); tx_load = 1'b0;
    tx_last_bit = 1'b1; cyc(); tx_last_bit = 1'b0;
    chk("R7 last bit with txe", 8'h85);
    xc_tdr_write = 1'b1; cyc(); xc_tdr_write = 1'b0;
    chk("R7 controller clears tend", 8'h01);
    // R13
    tx_load = 1'b1; xc_tdr_write = 1'b1; cyc(); tx_load = 1'b0; xc_tdr_write = 1'b0;
    chk("R13 set beats controller", 8'h81);
    rd();
    tx_load = 1'b1; wr(8'h00); tx_load = 1'b0;
    chk("R13 set beats sw clear", 8'h80);
    tx_enable = 1'b0; cyc(); tx_enable = 1'b1;
    chk("R6 R7 disabled transmitter", 8'h84);
    // receive path
    rx(8'h00, 1'b0, 1'b1, 1'b1);
    chk("R8 R12 receive full", 8'hC6);
    rx(8'h00, 1'b0, 1'b1, 1'b0);
    chk("R9 overrun", 8'hE4);
    rx(8'h00, 1'b0, 1'b0, 1'b0);
    chk("R10 framing", 8'hF4);
    xc_rdr_read = 1'b1; cyc(); xc_rdr_read = 1'b0;
    chk("R8 controller read", 8'hB4);
    rd(); wr(8'hC4);
    chk("R4 error clear", 8'h84);
    rx(8'h00, 1'b0, 1'b0, 1'b0);
    chk("R10 R8 framing no full", 8'h94);
    rd(); wr(8'hC4);
    chk("R4 framing clear", 8'h84);
    // R11 sweep
    parity_en = 1'b1;
    for (int m = 0; m < 2; m++) begin
      for (int d = 0; d < 256; d++) begin
        for (int p = 0; p < 2; p++) begin
          logic perr;
          logic [7:0] exp;
          parity_odd = m[0];
          perr = ((($countones(d[7:0]) + p) % 2) == 1) != m[0];
          exp = 8'h84 | (perr ? 8'h08 : 8'h40) | (d[0] ? 8'h02 : 8'h00);
          rx(d[7:0], p[0], 1'b1, d[0]);
          chk(perr ? "R11 parity error" : "R11 parity ok", exp);
          if (perr) begin
            rd(); wr(8'hC4);
          end else begin
            xc_rdr_read = 1'b1; cyc(); xc_rdr_read = 1'b0;
          end
        end
      end
    end
    finish_run();
  end
endmodule